// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational datapath stage. It takes two operands of a configurable width, a four-bit operation select and a carry input, and forms one result together with a carry-out and a zero indication. It is intended to sit between a register file and its write-back path. The surrounding logic supplies operands and a code in the same cycle and captures the outputs at the next clock edge.

Inside the block there are four paths. The arithmetic path is a ripple-carry adder whose second input passes through a four-way selector. The logic path is bitwise. The shift paths are single-position and fill the vacated bit with zero. Every result bit is chosen by its own four-way multiplexer, steered by the top two select bits. The lower two select bits and the carry input choose the variant within the arithmetic path, and the lower two bits alone choose the logic function.

Top module: `alsu_unit`

## Requirements
- R1: With sel_i = 4'b0000 the result equals a_i when cin_i = 0 and a_i + 1 (modulo 2^WIDTH) when cin_i = 1.
- R2: With sel_i = 4'b0001 the result equals a_i + b_i + cin_i, modulo 2^WIDTH.
- R3: With sel_i = 4'b0010 the result equals a_i + ~b_i + cin_i, modulo 2^WIDTH. With cin_i = 1 this is a_i - b_i.
- R4: With sel_i = 4'b0011 the result equals a_i + all-ones + cin_i. This gives a_i - 1 when cin_i = 0 and a_i when cin_i = 1.
- R5: With sel_i[3:2] = 2'b01 the result is bitwise. sel_i[1:0] = 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives the complement of a_i.
- R6: With sel_i[3:2] = 2'b10 the result is a_i shifted right by one, with 0 entering the most significant bit.
- R7: With sel_i[3:2] = 2'b11 the result is a_i shifted left by one, with 0 entering bit 0.
- R8: On the arithmetic path cout_o is the carry out of the most significant adder stage. On the logic and shift paths cout_o is 0.
- R9: zero_o is 1 exactly when every bit of f_o is 0.
- R10: On the logic and shift paths, cin_i has no effect on f_o or cout_o. On the shift paths, sel_i[1:0] and b_i have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand, also the shift source |
| b_i | input | WIDTH | Second operand |
| sel_i | input | 4 | Operation select; bits 3:2 choose the path, bits 1:0 choose the variant |
| cin_i | input | 1 | Carry input to the adder |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Adder carry-out, 0 off the arithmetic path |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The bench builds two copies of the block. One copy uses WIDTH = 4 and is swept over every combination of both operands, all sixteen codes and both carry values. This brings every carry chain, every wrap-around and every fill bit within reach. The other copy uses WIDTH = 8 and is swept over all first-operand values, with a few second-operand patterns, for each code and carry. This shows that the parameterised generate structure and the edge bits scale beyond the smallest width.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

   typedef enum logic [1:0] {
      PATH_ARITH = 2'b00,
      PATH_LOGIC = 2'b01,
      PATH_SHR   = 2'b10,
      PATH_SHL   = 2'b11
   } alsu_path_e;

   typedef enum logic [1:0] {
      BSEL_ZERO = 2'b00,
      BSEL_TRUE = 2'b01,
      BSEL_INV  = 2'b10,
      BSEL_ONES = 2'b11
   } alsu_bsel_e;

   typedef enum logic [1:0] {
      LOP_AND  = 2'b00,
      LOP_OR   = 2'b01,
      LOP_XOR  = 2'b10,
      LOP_NOTA = 2'b11
   } alsu_lop_e;

   localparam int unsigned SEL_W = 4;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
   import alsu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       var_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   logic [WIDTH-1:0] y_op;
   logic [WIDTH:0]   carry;

   always_comb begin
      unique case (alsu_bsel_e'(var_i))
         BSEL_ZERO: y_op = '0;
         BSEL_TRUE: y_op = b_i;
         BSEL_INV:  y_op = ~b_i;
         BSEL_ONES: y_op = '1;
         default:   y_op = '0;
      endcase
   end

   assign carry[0] = cin_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic p_bit;
      assign p_bit      = a_i[i] ^ y_op[i];
      assign sum_o[i]   = p_bit ^ carry[i];
      assign carry[i+1] = (a_i[i] & y_op[i]) | (p_bit & carry[i]);
   end

   assign cout_o = carry[WIDTH];

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
   import alsu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       op_i,
   output logic [WIDTH-1:0] res_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (alsu_lop_e'(op_i))
            LOP_AND:  res_o[i] = a_i[i] & b_i[i];
            LOP_OR:   res_o[i] = a_i[i] | b_i[i];
            LOP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
            LOP_NOTA: res_o[i] = ~a_i[i];
            default:  res_o[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/alsu_outmux.sv
module alsu_outmux
   import alsu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] arith_i,
   input  logic [WIDTH-1:0] logic_i,
   input  logic [1:0]       path_i,
   output logic [WIDTH-1:0] f_o
);

   localparam int unsigned TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic up_bit;
      logic dn_bit;

      if (i == TOP) begin : g_msb
         assign up_bit = 1'b0;
      end else begin : g_mid_hi
         assign up_bit = a_i[i+1];
      end

      if (i == 0) begin : g_lsb
         assign dn_bit = 1'b0;
      end else begin : g_mid_lo
         assign dn_bit = a_i[i-1];
      end

      always_comb begin
         unique case (alsu_path_e'(path_i))
            PATH_ARITH: f_o[i] = arith_i[i];
            PATH_LOGIC: f_o[i] = logic_i[i];
            PATH_SHR:   f_o[i] = up_bit;
            PATH_SHL:   f_o[i] = dn_bit;
            default:    f_o[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
   import alsu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       sel_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] f_o,
   output logic             cout_o,
   output logic             zero_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alsu_unit: WIDTH must be at least 2");
   end
   if (SEL_W != 4) begin : g_bad_sel
      $error("alsu_unit: select width must be 4");
   end

   logic [1:0]       path;
   logic [1:0]       variant;
   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] logic_res;
   logic             adder_cout;

   assign path    = sel_i[3:2];
   assign variant = sel_i[1:0];

   alsu_arith #(.WIDTH(WIDTH)) u_arith (
      .a_i    (a_i),
      .b_i    (b_i),
      .var_i  (variant),
      .cin_i  (cin_i),
      .sum_o  (arith_res),
      .cout_o (adder_cout)
   );

   alsu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .op_i  (variant),
      .res_o (logic_res)
   );

   alsu_outmux #(.WIDTH(WIDTH)) u_mux (
      .a_i     (a_i),
      .arith_i (arith_res),
      .logic_i (logic_res),
      .path_i  (path),
      .f_o     (f_o)
   );

   assign cout_o = (alsu_path_e'(path) == PATH_ARITH) ? adder_cout : 1'b0;
   assign zero_o = ~|f_o;

endmodule

// File: rtl/alsu_unit_chk.sv
module alsu_unit_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [3:0]       sel_i,
   input logic             cin_i,
   input logic [WIDTH-1:0] f_o,
   input logic             cout_o,
   input logic             zero_o
);

   always_comb begin
      if (sel_i[3:2] != 2'b00) begin
         assert_no_carry_off_arith_R8: assert (cout_o == 1'b0);
      end
      if (sel_i == 4'b0000 && !cin_i) begin
         assert_transfer_R1: assert (f_o == a_i && !cout_o);
      end
      if (sel_i == 4'b0011 && cin_i) begin
         assert_dec_cancel_R4: assert (f_o == a_i && cout_o);
      end
      if (sel_i == 4'b0100) begin
         assert_and_R5: assert (f_o == (a_i & b_i));
      end
      if (sel_i[3:2] == 2'b10) begin
         assert_shr_fill_R6: assert (!f_o[WIDTH-1] && f_o[WIDTH-2:0] == a_i[WIDTH-1:1]);
      end
      if (sel_i[3:2] == 2'b11) begin
         assert_shl_fill_R7: assert (!f_o[0] && f_o[WIDTH-1:1] == a_i[WIDTH-2:0]);
      end
      if (zero_o) begin
         assert_zero_flag_R9: assert (f_o == '0);
      end
   end

endmodule

bind alsu_unit alsu_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .sel_i  (sel_i),
   .cin_i  (cin_i),
   .f_o    (f_o),
   .cout_o (cout_o),
   .zero_o (zero_o)
);

// File: tb/sim_alsu_unit.sv
module sim_alsu_unit;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   logic [3:0] a4, b4;
   logic [7:0] a8, b8;
   logic [3:0] sel;
   logic       cin;
   logic [3:0] f4;
   logic [7:0] f8;
   logic       co4, co8, z4, z8;

   alsu_unit #(.WIDTH(4)) u0 (
      .a_i(a4), .b_i(b4), .sel_i(sel), .cin_i(cin),
      .f_o(f4), .cout_o(co4), .zero_o(z4)
   );

   alsu_unit #(.WIDTH(8)) u1 (
      .a_i(a8), .b_i(b8), .sel_i(sel), .cin_i(cin),
      .f_o(f8), .cout_o(co8), .zero_o(z8)
   );

   function automatic string req_of(input logic [3:0] s);
      case (s[3:2])
         2'b00:   req_of = (s[1:0] == 2'b00) ? "R1" : (s[1:0] == 2'b01) ? "R2" :
                           (s[1:0] == 2'b10) ? "R3" : "R4";
         2'b01:   req_of = "R5";
         2'b10:   req_of = "R6";
         default: req_of = "R7";
      endcase
   endfunction

   // reference result: {cout, f} packed into an int
   function automatic int model(input int a, input int b, input logic [3:0] s,
                                input logic c, input int w);
      int mask, y, sum, f, co;
      mask = (1 << w) - 1;
      co = 0;
      case (s[3:2])
         2'b00: begin
            case (s[1:0])
               2'b00:   y = 0;
               2'b01:   y = b;
               2'b10:   y = ~b & mask;
               default: y = mask;
            endcase
            sum = a + y + int'(c);
            f   = sum & mask;
            co  = (sum >> w) & 1;
         end
         2'b01: begin
            case (s[1:0])
               2'b00:   f = a & b;
               2'b01:   f = a | b;
               2'b10:   f = a ^ b;
               default: f = ~a & mask;
            endcase
         end
         2'b10:   f = a >> 1;
         default: f = (a << 1) & mask;
      endcase
      model = (co << w) | f;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s sel=%b cin=%b actual=%0h expected=%0h", req, what, sel, cin, act, exp);
      end
   endtask

   task automatic check_width(input int w, input int a, input int b);
      int e, ef, ec;
      e  = model(a, b, sel, cin, w);
      ef = e & ((1 << w) - 1);
      ec = (e >> w) & 1;
      if (w == 4) begin
         check(req_of(sel), "f", int'(f4), ef);
         check("R8", "cout", int'(co4), ec);
         check("R9", "zero", int'(z4), int'(ef == 0));
      end else begin
         check(req_of(sel), "f", int'(f8), ef);
         check("R8", "cout", int'(co8), ec);
         check("R9", "zero", int'(z8), int'(ef == 0));
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [3:0] f_ref4;
      logic       co_ref4;
      a4 = '0; b4 = '0; a8 = '0; b8 = '0; sel = '0; cin = 1'b0;
      @(negedge clk);
      // all-zero inputs: transfer of zero, zero flag raised (R1, R9)
      check("R1", "idle f", int'(f4), 0);
      check("R9", "idle zero", int'(z4), 1);

      // exhaustive sweep, WIDTH = 4
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 16; a++) begin
               for (int b = 0; b < 16; b++) begin
                  sel = 4'(s); cin = 1'(c); a4 = 4'(a); b4 = 4'(b);
                  @(negedge clk);
                  check_width(4, a, b);
               end
            end
         end
      end

      // R10: cin, and on shifts the variant bits and b, leave outputs unchanged
      for (int s = 4; s < 16; s++) begin
         for (int a = 0; a < 16; a++) begin
            sel = 4'(s); cin = 1'b0; a4 = 4'(a); b4 = 4'h5;
            @(negedge clk);
            f_ref4 = f4; co_ref4 = co4;
            cin = 1'b1;
            if (s >= 8) begin
               sel = {sel[3:2], ~sel[1:0]};
               b4 = 4'hA;
            end
            @(negedge clk);
            check("R10", "f unaffected", int'(f4), int'(f_ref4));
            check("R10", "cout unaffected", int'(co4), int'(co_ref4));
         end
      end

      // R3 boundary: a - a gives zero with carry out set
      sel = 4'b0010; cin = 1'b1; a4 = 4'h9; b4 = 4'h9;
      @(negedge clk);
      check("R3", "a-a f", int'(f4), 0);
      check("R8", "a-a cout", int'(co4), 1);
      check("R9", "a-a zero", int'(z4), 1);

      // WIDTH = 8 sweep
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 256; a++) begin
               for (int k = 0; k < 4; k++) begin
                  int b;
                  b = (k == 0) ? 0 : (k == 1) ? 255 : (k == 2) ? 8'h5A : 8'h81;
                  sel = 4'(s); cin = 1'(c); a8 = 8'(a); b8 = 8'(b);
                  @(negedge clk);
                  check_width(8, a, b);
               end
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule